// File: doc/BRIEF.md
# Output-Compare Channel with Glitch-Free Pulse-Width Modulation

This block is one output-compare channel. It watches the count of a free-running timer that lives outside the block and drives one output pin. In the single-compare modes it drives the pin high, drives it low, or toggles it when the timer count equals a primary compare value. In the pulse-width mode it raises the pin at every period boundary and lowers it once the timer has spent as many cycles in the period as a double-buffered duty value asks for. Each compare event, and each period boundary in the pulse-width mode, raises a one-cycle interrupt flag.

Two cases get special care. A duty value of zero gives a pin that stays low for the whole period, with no one-cycle spike at the boundary. The next non-zero duty is applied on the following boundary as normal. When a mode that can drive the pin low is switched on while the pin is already high, the pin keeps its level until the first real match. It never drops for a cycle at the moment of enabling. While the channel is disabled, the pin follows the port-latch level `pin_init`, so a later compare mode starts from that level.

The controller is a four-state machine. **IDLE** is the disabled state: the pin copies `pin_init`. **ARMED** is a single-compare mode waiting for a match. **HELD** is a drive-high or drive-low compare that has fired and now holds the pin. **PWM** is the pulse-width mode. The transitions are named as follows:
- *reconfigure*: any change of the decoded mode, taken from any state to IDLE, ARMED or PWM according to the new mode.
- *fire*: ARMED to HELD on a match in the drive-high or drive-low mode.
- *retoggle*: ARMED to ARMED on a match in the toggle mode.
- Every other state loops on itself.

Top module: `ocmp_channel`

## Requirements
- R1: During reset and in the first cycle after reset, with `pin_init` low, `oc_pin` and `oc_irq` are both 0.
- R2: The mode field is decoded as follows: 3'd1 is drive-high compare, 3'd2 is drive-low compare, 3'd3 is toggle compare and 3'd6 is pulse-width mode. Every other code, 3'd0 included, disables the channel. While the channel is disabled, `oc_pin` equals the `pin_init` value from the previous cycle and `oc_irq` stays 0, even when the timer meets `cmp_pri`.
- R3: In drive-high mode, `oc_pin` goes to 1 in the cycle after the one in which `tmr_count` equals `cmp_pri`. It then stays at 1 with no further interrupts until the mode changes.
- R4: In drive-low mode, `oc_pin` goes to 0 in the cycle after the match. A pin that was high when the mode was enabled stays high through every cycle before that, whatever `pin_init` does meanwhile.
- R5: In toggle mode, `oc_pin` inverts in the cycle after every match, once per timer period.
- R6: In pulse-width mode, with an active duty D where 0 < D ≤ terminal count, `oc_pin` is 1 while `tmr_count` < D and 0 for the rest of the period. The period boundary is the cycle in which `period_match` is 1.
- R7: The duty value `cmp_sec` is sampled only in a boundary cycle. A value written in the middle of a period and replaced before the next boundary has no effect on `oc_pin`.
- R8: A duty of 0 keeps `oc_pin` at 0 through the whole period, including the cycle that follows the boundary, even when the previous period was high.
- R9: After a period with duty 0, a non-zero duty written before the next boundary takes effect in the very next period.
- R10: A duty greater than or equal to the period length (terminal count + 1) keeps `oc_pin` at 1 for the whole period.
- R11: `oc_irq` is a one-cycle pulse. In a single-compare mode it is raised in the cycle after a match. In pulse-width mode it is raised in the cycle after each boundary.
- R12: On a change into a compare mode, `oc_pin` keeps its level in the cycle of the change. Matches count from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_count | input | W | Count of the external free-running timer |
| period_match | input | 1 | High in the cycle the timer holds its terminal count |
| mode | input | 3 | Mode code (see R2) |
| cmp_pri | input | W | Primary compare value for the single-compare modes |
| cmp_sec | input | W | Duty value for pulse-width mode, double-buffered |
| pin_init | input | 1 | Port-latch level, copied to the pin while disabled |
| oc_pin | output | 1 | Compare output pin |
| oc_irq | output | 1 | One-cycle interrupt flag |

## Verification
The hardest situation to reach is a boundary at which the duty buffer receives zero right after a period that ended high. This is where a one-cycle spike would appear. The bench runs its own timer and writes each duty in the last cycle of the preceding period. It chains a normal period, two zero periods and then a small non-zero period, so the zero-to-non-zero case is covered as well. The glitch-at-enable case is reached by first parking the channel disabled with `pin_init` high. Drive-low mode is then enabled four cycles ahead of a match, and `pin_init` is flipped while the channel waits.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int unsigned MODE_W = 3;

    localparam logic [MODE_W-1:0] ENC_HIGH   = 3'd1;
    localparam logic [MODE_W-1:0] ENC_LOW    = 3'd2;
    localparam logic [MODE_W-1:0] ENC_TOGGLE = 3'd3;
    localparam logic [MODE_W-1:0] ENC_PWM    = 3'd6;

    typedef enum logic [2:0] {
        OM_OFF,
        OM_HIGH,
        OM_LOW,
        OM_TOGGLE,
        OM_PWM
    } oc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HELD,
        ST_PWM
    } oc_state_e;

    function automatic oc_mode_e decode_mode(input logic [MODE_W-1:0] enc);
        oc_mode_e m;
        case (enc)
            ENC_HIGH:   m = OM_HIGH;
            ENC_LOW:    m = OM_LOW;
            ENC_TOGGLE: m = OM_TOGGLE;
            ENC_PWM:    m = OM_PWM;
            default:    m = OM_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int unsigned W         = 16,
    parameter bit          LOOKAHEAD = 1'b0
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] ref_val,
    output logic         hit
);
    localparam int unsigned XW = W + 1;

    generate
        if (LOOKAHEAD) begin : g_ahead
            // Fires one cycle before the count reaches ref_val; never for ref_val 0.
            logic [XW-1:0] next_cnt;
            assign next_cnt = {1'b0, count} + XW'(1);
            assign hit      = (next_cnt == {1'b0, ref_val});
        end else begin : g_exact
            assign hit = (count == ref_val);
        end
    endgenerate

endmodule

// File: rtl/ocmp_duty_buf.sv
module ocmp_duty_buf #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/ocmp_fsm.sv
module ocmp_fsm
    import ocmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  oc_mode_e  mode_dec,
    input  logic      pin_init,
    input  logic      period_match,
    input  logic      cmp_hit,
    input  logic      duty_hit,
    input  logic      next_duty_nz,
    output oc_state_e state,
    output logic      reconf,
    output logic      duty_load,
    output logic      pin,
    output logic      irq
);

    oc_state_e state_q;
    oc_state_e state_d;
    oc_mode_e  mode_q;
    logic      pin_q;
    logic      irq_q;

    assign reconf    = (mode_dec != mode_q);
    assign duty_load = reconf ? (mode_dec == OM_PWM)
                              : ((state_q == ST_PWM) && period_match);

    // Next state
    always_comb begin
        state_d = state_q;
        if (reconf) begin
            unique case (mode_dec)
                OM_OFF:                      state_d = ST_IDLE;
                OM_HIGH, OM_LOW, OM_TOGGLE:  state_d = ST_ARMED;
                OM_PWM:                      state_d = ST_PWM;
                default:                     state_d = ST_IDLE;
            endcase
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (cmp_hit && (mode_q != OM_TOGGLE)) begin
                        state_d = ST_HELD;
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= OM_OFF;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_dec;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (reconf) begin
                // Entering a compare or PWM mode keeps the present level.
                if (mode_dec == OM_OFF) begin
                    pin_q <= pin_init;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: pin_q <= pin_init;
                    ST_ARMED: begin
                        if (cmp_hit) begin
                            irq_q <= 1'b1;
                            case (mode_q)
                                OM_HIGH: pin_q <= 1'b1;
                                OM_LOW:  pin_q <= 1'b0;
                                default: pin_q <= ~pin_q;
                            endcase
                        end
                    end
                    ST_HELD: pin_q <= pin_q;
                    ST_PWM: begin
                        if (period_match) begin
                            irq_q <= 1'b1;
                            pin_q <= next_duty_nz;
                        end else if (duty_hit) begin
                            pin_q <= 1'b0;
                        end
                    end
                    default: pin_q <= pin_q;
                endcase
            end
        end
    end

    assign state = state_q;
    assign pin   = pin_q;
    assign irq   = irq_q;

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      tmr_count,
    input  logic              period_match,
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      cmp_pri,
    input  logic [W-1:0]      cmp_sec,
    input  logic              pin_init,
    output logic              oc_pin,
    output logic              oc_irq
);

    oc_mode_e  mode_dec;
    oc_state_e fsm_state;
    logic      fsm_reconf;
    logic      duty_load;
    logic      cmp_hit;
    logic      duty_hit;
    logic      next_duty_nz;
    logic [W-1:0] duty_act;

    assign mode_dec     = decode_mode(mode);
    assign next_duty_nz = (cmp_sec != '0);

    ocmp_duty_buf #(.W(W)) u_duty (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (duty_load),
        .din   (cmp_sec),
        .dout  (duty_act)
    );

    ocmp_match #(.W(W), .LOOKAHEAD(1'b0)) u_cmp_match (
        .count   (tmr_count),
        .ref_val (cmp_pri),
        .hit     (cmp_hit)
    );

    ocmp_match #(.W(W), .LOOKAHEAD(1'b1)) u_duty_match (
        .count   (tmr_count),
        .ref_val (duty_act),
        .hit     (duty_hit)
    );

    ocmp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_dec     (mode_dec),
        .pin_init     (pin_init),
        .period_match (period_match),
        .cmp_hit      (cmp_hit),
        .duty_hit     (duty_hit),
        .next_duty_nz (next_duty_nz),
        .state        (fsm_state),
        .reconf       (fsm_reconf),
        .duty_load    (duty_load),
        .pin          (oc_pin),
        .irq          (oc_irq)
    );

endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk
    import ocmp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic              period_match,
    input logic [W-1:0]      cmp_sec,
    input logic              pin_init,
    input logic              oc_pin,
    input logic              oc_irq,
    input oc_state_e         state,
    input logic              reconf,
    input logic              cmp_hit,
    input logic [W-1:0]      duty_act
);

    // R8
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && !reconf && period_match && cmp_sec == '0) |=> !oc_pin);

    // R6
    pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && !reconf && period_match && cmp_sec != '0) |=> oc_pin);

    // R7
    duty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && !reconf && period_match) |=> (duty_act == $past(cmp_sec)));

    // R11
    pwm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && !reconf && period_match) |=> oc_irq);

    // R4
    hold_until_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !reconf && !cmp_hit) |=> $stable(oc_pin));

    // R12
    reconf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf && decode_mode(mode) != OM_OFF) |=> $stable(oc_pin));

    // R3
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !reconf) |=> ($stable(oc_pin) && !oc_irq));

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !reconf) |=> (oc_pin == $past(pin_init) && !oc_irq));

endmodule

bind ocmp_channel ocmp_channel_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .period_match (period_match),
    .cmp_sec      (cmp_sec),
    .pin_init     (pin_init),
    .oc_pin       (oc_pin),
    .oc_irq       (oc_irq),
    .state        (fsm_state),
    .reconf       (fsm_reconf),
    .cmp_hit      (cmp_hit),
    .duty_act     (duty_act)
);

// File: tb/ocmp_channel_tb.sv
module ocmp_channel_tb;

    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int PRD        = 9;
    localparam int PLEN       = PRD + 1;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tmr = '0;
    logic         period_match;
    logic [2:0]   mode = 3'd0;
    logic [W-1:0] cmp_pri = '0;
    logic [W-1:0] cmp_sec = '0;
    logic         pin_init = 1'b0;
    logic         oc_pin;
    logic         oc_irq;

    typedef struct {
        logic  pin;
        logic  irq;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks   = 0;
    int   fails    = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Free-running timer model, 0..PRD
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr <= '0;
        else        tmr <= (tmr == W'(PRD)) ? '0 : tmr + 1'b1;
    end
    assign period_match = rst_n && (tmr == W'(PRD));

    ocmp_channel #(.W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_count    (tmr),
        .period_match (period_match),
        .mode         (mode),
        .cmp_pri      (cmp_pri),
        .cmp_sec      (cmp_sec),
        .pin_init     (pin_init),
        .oc_pin       (oc_pin),
        .oc_irq       (oc_irq)
    );

    task automatic check(input logic gp, input logic gi, input logic ep, input logic ei,
                         input string tag);
        checks++;
        if (gp !== ep || gi !== ei) begin
            fails++;
            $display("FAIL %s: pin,irq got %b,%b expected %b,%b", tag, gp, gi, ep, ei);
        end
    endtask

    task automatic push(input logic p, input logic i, input string tag);
        exp_t e;
        e.pin = p;
        e.irq = i;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: one expected item per cycle, compared away from the active edge
    always @(negedge clk) begin : monitor
        exp_t e;
        if (sb_q.size() != 0) begin
            e = sb_q.pop_front();
            check(oc_pin, oc_irq, e.pin, e.irq, e.tag);
        end
    end

    // Park the channel disabled at a level, then run one single-compare mode
    task automatic single_test(input logic [2:0] enc, input logic init, input string tag);
        int t0;
        int nh;
        logic ep;
        logic ei;
        bit hit;
        drain();
        @(negedge clk);
        mode     = 3'd0;
        pin_init = init;
        #2;
        push(init, 1'b0, "R2 disabled copies pin_init");
        push(init, 1'b0, "R2 disabled copies pin_init");
        drain();
        @(negedge clk);
        t0      = int'(tmr);
        cmp_pri = W'((t0 + 4) % PLEN);
        mode    = enc;
        #2;
        nh = 0;
        for (int k = 1; k <= 2 * PLEN + 6; k++) begin
            hit = (k >= 5) && (((k - 5) % PLEN) == 0);
            if (hit) nh++;
            case (enc)
                3'd1:    ep = (nh > 0) ? 1'b1 : init;
                3'd2:    ep = (nh > 0) ? 1'b0 : init;
                default: ep = init ^ nh[0];
            endcase
            if (enc == 3'd3) ei = hit;
            else             ei = hit && (nh == 1);
            push(ep, ei, (k < 5) ? {tag, " / R12 hold before match"} : tag);
        end
        // pin_init must not matter once a compare mode is on
        @(negedge clk);
        pin_init = ~init;
    endtask

    task automatic pwm_period(input int d, input int dmid, input string tag);
        do @(negedge clk); while (tmr != W'(PRD));
        cmp_sec = W'(d);
        #2;
        for (int t = 0; t <= PRD; t++) begin
            push((t < d), (t == 0), tag);
        end
        do @(negedge clk); while (tmr != W'(PRD / 2));
        cmp_sec = W'(dmid);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        check(oc_pin, oc_irq, 1'b0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(oc_pin, oc_irq, 1'b0, 1'b0, "R1 after reset");

        single_test(3'd1, 1'b0, "R3 drive-high");
        single_test(3'd2, 1'b1, "R4 drive-low from high");
        single_test(3'd3, 1'b0, "R5 toggle");
        single_test(3'd2, 1'b0, "R4 drive-low from low");

        // Unused mode code behaves as disabled
        drain();
        @(negedge clk);
        mode     = 3'd4;
        pin_init = 1'b1;
        cmp_pri  = W'((int'(tmr) + 2) % PLEN);
        #2;
        push(1'b1, 1'b0, "R2 code 4 disabled");
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            pin_init = j[0];
            #2;
            push(j[0], 1'b0, "R2 code 4 follows pin_init, no irq");
        end

        // Pulse-width mode
        drain();
        @(negedge clk);
        mode    = 3'd6;
        cmp_sec = '0;
        pwm_period(5, 1, "R6 duty 5");
        pwm_period(5, 2, "R7 mid-period write ignored");
        pwm_period(0, 0, "R8 zero after high period");
        pwm_period(0, 6, "R8 zero twice");
        pwm_period(3, 3, "R9 first non-zero after zero");
        pwm_period(PLEN, PLEN, "R10 duty equals period");
        pwm_period(255, 255, "R10 duty above period");
        pwm_period(1, 1, "R6 duty 1");
        pwm_period(PRD, 0, "R6 duty terminal");
        pwm_period(0, 0, "R8 zero after near-full");
        drain();
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule